// File: doc/BRIEF.md
# Shadowed Compare Timer with Prescaler

This block is a 16-bit up-counting timer that advances on ticks produced by a power-of-two prescaler. A 3-bit rate code picks a divide ratio from 1 to 128. An optional stage multiplies that ratio by a further 256. The counter restarts from zero when it reaches the active period value. A compare-state output is high while the count is at or above the active compare value, and a passive-level bit can invert it. Single-cycle pulses mark period matches and compare matches.

A run flag gates counting. Software strobes and hardware event inputs can raise or drop the flag. If more than one of these requests arrives in the same cycle, the flag keeps its value. New period, compare and passive-level values go first into a shadow set. That set moves into the active registers only on a period match, and only while the transfer-enable flag is armed. The flag drops by itself once the transfer happens.

Top module: `shadow_cmp_timer`

## Requirements
- R1: With the extra stage off and rate code N (0 to 7), a running counter changes value once every 2^N clock cycles. The first change after a start comes 2^N cycles after `running` first reads 1.
- R2: With `pre256` set, the interval becomes 256 * 2^N cycles.
- R3: While `running` is 0 the count holds its value. The prescaler restarts on every start, so the first tick after a start always comes a full interval later, even if an earlier run stopped part way through an interval.
- R4: A lone request sets or clears `running` one cycle later. `run_set` and `hw_start` set it; `run_clr` and `hw_stop` clear it.
- R5: When two or more of `run_set`, `run_clr`, `hw_start` and `hw_stop` are high in the same cycle, `running` keeps its previous value.
- R6: On a tick where the count equals the active period, the count goes to 0. In the cycle where that 0 first shows, `period_hit` is 1 for one cycle. On any other tick the count goes up by one.
- R7: `cmp_state` equals (count >= active compare) XOR the active passive-level bit.
- R8: `compare_hit` is 1 for one cycle when a tick moves the count onto the active compare value. It is high in the same cycle that value first shows.
- R9: When `xfer_en` is 1 and a period match occurs, the shadow period, compare and passive bit become active at that edge, and `xfer_en` reads 0 afterwards.
- R10: With `xfer_en` at 0, a period match leaves the active values unchanged, even after the shadow set has been rewritten with `shd_wr`.
- R11: `xfer_arm` sets `xfer_en` at the next edge. If it coincides with a transfer, `xfer_en` ends at 1.
- R12: After reset the count is 0, `running` is 0 and `xfer_en` is 0. No pulse is active, and the active period, compare and passive bit are all 0, so `cmp_state` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| rate_sel | input | 3 | Power-of-two divide code N |
| pre256 | input | 1 | Enables the extra divide by 256 |
| run_set | input | 1 | Software start strobe |
| run_clr | input | 1 | Software stop strobe |
| hw_start | input | 1 | Hardware start event |
| hw_stop | input | 1 | Hardware stop event |
| shd_wr | input | 1 | Writes the shadow set |
| shd_period | input | 16 | Shadow period value |
| shd_compare | input | 16 | Shadow compare value |
| shd_passive | input | 1 | Shadow passive-level bit |
| xfer_arm | input | 1 | Arms the shadow transfer |
| count | output | 16 | Current count |
| running | output | 1 | Run flag |
| xfer_en | output | 1 | Transfer-enable flag |
| cmp_state | output | 1 | Compare state after passive inversion |
| period_hit | output | 1 | Period-match pulse |
| compare_hit | output | 1 | Compare-match pulse |

## Verification
The assertions assume that no run request and no `xfer_arm` strobe arrives while reset is asserted or during the two cycles the internal reset takes to release. The bench raises every strobe only after that settling time. The transfer check also assumes that `xfer_arm` is the only thing that can raise `xfer_en`. The bench drives each strobe for exactly one cycle, between falling edges. It changes the rate code and the extra-stage enable only while the timer is stopped, so every measured interval belongs to a single setting.

// File: rtl/sct_pkg.sv
`timescale 1ns/1ps
package sct_pkg;
  parameter int unsigned CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef struct packed {
    cnt_t period;
    cnt_t compare;
    logic passive;
  } tset_t;
endpackage

// File: rtl/sct_prescaler.sv
`timescale 1ns/1ps
module sct_prescaler #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned XPRE_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic             xpre,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 1 + XPRE_LOG2;

  logic [DIV_W-1:0] div_q, div_d, mask;
  int unsigned      shift;

  always_comb begin
    shift = int'(sel) + (xpre ? XPRE_LOG2 : 0);
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < shift);
    end
    tick  = run && ((div_q & mask) == mask);
    div_d = run ? div_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/sct_run_ctrl.sv
`timescale 1ns/1ps
module sct_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic ev_start,
  input  logic ev_stop,
  output logic run
);
  logic       run_q, run_d;
  logic [3:0] reqs;
  logic [2:0] nreq;

  always_comb begin
    reqs = {sw_set, sw_clr, ev_start, ev_stop};
    nreq = 3'($countones(reqs));
    // a lone request decides; none or a collision keeps the flag
    run_d = (nreq == 3'd1) ? (sw_set | ev_start) : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign run = run_q;
endmodule

// File: rtl/sct_shadow.sv
`timescale 1ns/1ps
module sct_shadow
  import sct_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  tset_t wr_set,
  input  logic  arm,
  input  logic  period_match,
  output tset_t act,
  output logic  xfer_en
);
  tset_t shd_q, act_q, act_d;
  logic  xen_q, xen_d, do_xfer;

  always_comb begin
    do_xfer = period_match && xen_q;
    act_d   = do_xfer ? shd_q : act_q;
    // software arming outranks the hardware clear
    xen_d   = arm ? 1'b1 : (do_xfer ? 1'b0 : xen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
      xen_q <= 1'b0;
    end else begin
      if (wr) shd_q <= wr_set;
      act_q <= act_d;
      xen_q <= xen_d;
    end
  end

  assign act     = act_q;
  assign xfer_en = xen_q;
endmodule

// File: rtl/sct_counter.sv
`timescale 1ns/1ps
module sct_counter
  import sct_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  tset_t act,
  output cnt_t  count,
  output logic  period_match,
  output logic  period_hit,
  output logic  compare_hit,
  output logic  cmp_state
);
  cnt_t cnt_q, cnt_d;
  logic ph_q, ph_d, ch_q, ch_d;

  always_comb begin
    period_match = tick && (cnt_q == act.period);
    if (!tick)             cnt_d = cnt_q;
    else if (period_match) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
    ph_d = period_match;
    ch_d = tick && (cnt_d == act.compare);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
      ch_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
      ch_q  <= ch_d;
    end
  end

  assign count       = cnt_q;
  assign period_hit  = ph_q;
  assign compare_hit = ch_q;
  assign cmp_state   = (cnt_q >= act.compare) ^ act.passive;
endmodule

// File: rtl/shadow_cmp_timer.sv
`timescale 1ns/1ps
module shadow_cmp_timer
  import sct_pkg::*;
#(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned XPRE_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             pre256,
  input  logic             run_set,
  input  logic             run_clr,
  input  logic             hw_start,
  input  logic             hw_stop,
  input  logic             shd_wr,
  input  logic [CNT_W-1:0] shd_period,
  input  logic [CNT_W-1:0] shd_compare,
  input  logic             shd_passive,
  input  logic             xfer_arm,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             xfer_en,
  output logic             cmp_state,
  output logic             period_hit,
  output logic             compare_hit
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       tick, pmatch;
  tset_t      wr_set, act;

  // asynchronous assertion, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign wr_set = '{period: shd_period, compare: shd_compare, passive: shd_passive};

  sct_run_ctrl i_run (
    .clk(clk), .rst_n(rst_int_n),
    .sw_set(run_set), .sw_clr(run_clr),
    .ev_start(hw_start), .ev_stop(hw_stop),
    .run(running)
  );

  sct_prescaler #(.SEL_W(SEL_W), .XPRE_LOG2(XPRE_LOG2)) i_pre (
    .clk(clk), .rst_n(rst_int_n), .run(running),
    .sel(rate_sel), .xpre(pre256), .tick(tick)
  );

  sct_shadow i_shd (
    .clk(clk), .rst_n(rst_int_n), .wr(shd_wr), .wr_set(wr_set),
    .arm(xfer_arm), .period_match(pmatch), .act(act), .xfer_en(xfer_en)
  );

  sct_counter i_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .act(act),
    .count(count), .period_match(pmatch), .period_hit(period_hit),
    .compare_hit(compare_hit), .cmp_state(cmp_state)
  );
endmodule

// File: rtl/shadow_cmp_timer_chk.sv
`timescale 1ns/1ps
module shadow_cmp_timer_chk
  import sct_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run_set,
  input logic             run_clr,
  input logic             hw_start,
  input logic             hw_stop,
  input logic             xfer_arm,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic             xfer_en,
  input logic             period_hit
);
  logic [3:0] reqs;
  assign reqs = {run_set, run_clr, hw_start, hw_stop};

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (count == $past(count)));

  p_collision_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(reqs) > 1) |=> (running == $past(running)));

  p_lone_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones(reqs) == 1) && (run_set || hw_start)) |=> running);

  p_lone_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones(reqs) == 1) && (run_clr || hw_stop)) |=> !running);

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count == CNT_W'($past(count) + 1'b1)) || (count == '0)));

  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    period_hit |-> (count == '0));

  p_xfer_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_hit && !$past(xfer_arm)) |-> !xfer_en);

  p_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_arm |=> xfer_en);
endmodule

bind shadow_cmp_timer shadow_cmp_timer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .run_set(run_set), .run_clr(run_clr),
  .hw_start(hw_start), .hw_stop(hw_stop), .xfer_arm(xfer_arm),
  .count(count), .running(running), .xfer_en(xfer_en), .period_hit(period_hit)
);

// File: tb/test_shadow_cmp_timer.sv
`timescale 1ns/1ps
module test_shadow_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  rate_sel;
  logic        pre256, run_set, run_clr, hw_start, hw_stop;
  logic        shd_wr, shd_passive, xfer_arm;
  logic [15:0] shd_period, shd_compare, count;
  logic        running, xfer_en, cmp_state, period_hit, compare_hit;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 4 ns period

  shadow_cmp_timer i_shadow_cmp_timer (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_req(input bit s, input bit c, input bit hs, input bit hc);
    run_set = s; run_clr = c; hw_start = hs; hw_stop = hc;
    cyc();
    run_set = 0; run_clr = 0; hw_start = 0; hw_stop = 0;
  endtask

  task automatic write_shadow(input int p, input int c, input bit pas);
    shd_period = 16'(p); shd_compare = 16'(c); shd_passive = pas; shd_wr = 1;
    cyc();
    shd_wr = 0;
  endtask

  // load a new active set through an armed transfer at full rate
  task automatic configure(input int p, input int c, input bit pas);
    rate_sel = 0; pre256 = 0;
    write_shadow(p, c, pas);
    xfer_arm = 1; cyc(); xfer_arm = 0;
    if (!running) run_req(1, 0, 0, 0);
    for (int i = 0; i < 200 && xfer_en; i++) cyc();
    chk(!xfer_en && count == 0, "R9", xfer_en, 0);
  endtask

  // cycle-by-cycle model at full rate
  task automatic run_model(input int p, input int c, input bit pas, input int n);
    int prv, exp;
    prv = count;
    for (int i = 0; i < n; i++) begin
      cyc();
      exp = (prv == p) ? 0 : prv + 1;
      chk(count == exp, "R6 count", count, exp);
      chk(period_hit == (prv == p), "R6 period_hit", period_hit, prv == p);
      chk(compare_hit == (exp == c), "R8 compare_hit", compare_hit, exp == c);
      chk(cmp_state == ((exp >= c) ^ pas), "R7 cmp_state", cmp_state, (exp >= c) ^ pas);
      prv = count;
    end
  endtask

  task automatic measure(output int cycles);
    logic [15:0] prv;
    prv = count;
    cycles = 0;
    do begin
      cyc();
      cycles++;
    end while (count == prv && cycles < 5000);
  endtask

  task automatic wait_count(input int v);
    for (int i = 0; i < 300 && count != 16'(v); i++) cyc();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int iv;
    rst_n = 0; rate_sel = 0; pre256 = 0;
    run_set = 0; run_clr = 0; hw_start = 0; hw_stop = 0;
    shd_wr = 0; shd_period = 0; shd_compare = 0; shd_passive = 0; xfer_arm = 0;
    cyc(3);
    rst_n = 1;
    cyc(4);

    // R12 reset state
    chk(count == 0, "R12 count", count, 0);
    chk(!running, "R12 running", running, 0);
    chk(!xfer_en, "R12 xfer_en", xfer_en, 0);
    chk(!period_hit && !compare_hit, "R12 pulses", {period_hit, compare_hit}, 0);
    chk(cmp_state, "R12 cmp_state", cmp_state, 1);

    // R9, R6, R7, R8 with both passive levels
    configure(5, 3, 0);
    run_model(5, 3, 0, 20);
    configure(7, 2, 1);
    run_model(7, 2, 1, 24);

    // R11: arm coinciding with a transfer
    configure(4, 2, 0);
    write_shadow(6, 4, 1);
    wait_count(1);
    xfer_arm = 1; cyc(); xfer_arm = 0;
    wait_count(4);
    xfer_arm = 1; cyc(); xfer_arm = 0;
    chk(count == 0, "R11 count", count, 0);
    chk(xfer_en, "R11 xfer_en kept", xfer_en, 1);
    run_model(6, 4, 1, 8);  // second transfer at count 6 with same set
    chk(!xfer_en, "R9 self clear", xfer_en, 0);

    // R10: rewritten shadow without arming is not taken
    write_shadow(9, 1, 0);
    run_model(6, 4, 1, 30);
    chk(!xfer_en, "R10 xfer_en", xfer_en, 0);

    // R1 / R2 sweep of prescale settings
    configure(20, 10, 0);
    for (int x = 0; x < 2; x++) begin
      for (int n = 0; n < 8; n++) begin
        if (x == 1 && n > 1) continue;
        run_req(0, 1, 0, 0);
        rate_sel = 3'(n); pre256 = x[0];
        run_req(1, 0, 0, 0);
        measure(iv);
        chk(iv == ((1 << n) << (8 * x)), x ? "R2 first" : "R1 first", iv, (1 << n) << (8 * x));
        measure(iv);
        chk(iv == ((1 << n) << (8 * x)), x ? "R2 next" : "R1 next", iv, (1 << n) << (8 * x));
      end
    end

    // R3: hold while stopped, prescaler restart
    begin
      logic [15:0] held;
      run_req(0, 1, 0, 0);
      held = count;
      cyc(40);
      chk(count == held && !running, "R3 hold", count, held);
      rate_sel = 3; pre256 = 0;
      run_req(1, 0, 0, 0);
      cyc(5);
      run_req(0, 1, 0, 0);
      cyc(3);
      run_req(1, 0, 0, 0);
      measure(iv);
      chk(iv == 8, "R3 restart", iv, 8);
    end

    // R4: lone requests
    run_req(0, 1, 0, 0); chk(!running, "R4 run_clr", running, 0);
    run_req(0, 0, 1, 0); chk(running, "R4 hw_start", running, 1);
    run_req(0, 0, 0, 1); chk(!running, "R4 hw_stop", running, 0);
    run_req(1, 0, 0, 0); chk(running, "R4 run_set", running, 1);

    // R5: collisions from both states
    run_req(0, 1, 0, 1); chk(running, "R5 clr+stop", running, 1);
    run_req(1, 1, 0, 0); chk(running, "R5 set+clr", running, 1);
    run_req(0, 0, 1, 1); chk(running, "R5 start+stop", running, 1);
    run_req(0, 1, 0, 0);
    run_req(1, 0, 1, 0); chk(!running, "R5 set+start", running, 0);
    run_req(1, 1, 1, 1); chk(!running, "R5 all four", running, 0);
    run_req(1, 0, 0, 1); chk(!running, "R5 set+stop", running, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule